// File: doc/BRIEF.md
# Shared-Pool Destination Queue Buffer

This buffer sits on the input side of a crossbar port. It takes 72-bit packets one per cycle and keeps them in a common pool of 32 slots. Each of the 8 destinations has its own queue, built as a linked list through that pool. Per-destination head and tail pointer arrays, together with one next-slot array, hold the order of each queue. A bitmap of free slots tracks which slots are unused. Because all queues draw on the same pool, a busy destination can take any number of slots, and no capacity sits unused in idle queues.

The buffer presents the set of non-empty queues to an external arbiter as a request vector. When the arbiter names a destination with a transmit request, the buffer removes the oldest packet of that queue and returns its slot to the free pool. The packet is loaded into a shift register and leaves as two 36-bit beats, the upper half first. A request for an empty queue produces a one-cycle flag and no data. When every slot is occupied, the buffer raises a full indication and refuses new packets, so the sender must hold them.

Top module: `voq_link_buffer`

## Requirements
- R1: After reset, in_full, req_vec, out_valid, out_last and tx_empty are all 0.
- R2: An accepted packet joins the queue selected by its top three bits (in_pkt[71:69]). The matching req_vec bit reads 1 in the cycle after the edge that accepted it.
- R3: Packets to one destination leave in the order they arrived, whatever traffic the other destinations carry.
- R4: When a transmit request is accepted at an edge, the next cycle shows out_valid=1, out_last=0 and in_pkt[71:36] of the packet. The cycle after that shows out_valid=1, out_last=1 and bits [35:0]. After that, out_valid returns to 0 unless a new packet was loaded.
- R5: req_vec[d] is 1 exactly when queue d holds at least one packet.
- R6: A transmit request accepted for an empty queue produces no beats and raises tx_empty for exactly the following cycle.
- R7: With 32 packets stored, in_full is 1 and in_valid has no effect. A packet presented while full is never stored and never sent.
- R8: A transmit request made while the upper beat is on the output is ignored. A request made while the lower beat is on the output is accepted, so packets can stream with no gap.
- R9: An enqueue and a dequeue in the same cycle both take effect. This holds when they target the same queue, both for a queue with one packet and for an empty queue.
- R10: Slots freed by dequeues are reused, so the full 32-packet capacity is available again after draining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet present on in_pkt |
| in_pkt | input | 72 | Incoming packet; bits [71:69] select the destination |
| in_full | output | 1 | All slots occupied; in_valid is ignored |
| req_vec | output | 8 | One bit per destination with a non-empty queue |
| tx_req | input | 1 | Transmit request from the arbiter |
| tx_dest | input | 3 | Destination whose head packet is requested |
| tx_empty | output | 1 | Previous accepted request found its queue empty |
| out_valid | output | 1 | out_beat carries a packet half |
| out_beat | output | 36 | Packet half, upper half first |
| out_last | output | 1 | Current beat is the lower (second) half |

## Verification
The bench aims at the cases where the linked lists can come apart. One case is a dequeue and an enqueue on a queue that holds a single packet. Here a design that follows the stale next pointer loses the new packet or sends garbage. Another case is an enqueue into an empty queue in the same cycle as a request for it, which must raise tx_empty and still keep the packet. The bench fills the pool to 32 and then presents extra packets. A buffer that overwrote a slot would later send a dropped packet or lose a stored one. Back-to-back requests probe the beat boundary, where a serializer that reloads too early truncates the lower half. Random mixed traffic then checks queue order against a per-destination model.

// File: rtl/voq_pkg.sv
// Package voq_pkg
// Holds the default dimensions of the destination queue buffer and the
// state type of its output serializer. Assumes nothing about the user.
package voq_pkg;
    localparam int unsigned VOQ_PKT_W = 72;
    localparam int unsigned VOQ_DEPTH = 32;
    localparam int unsigned VOQ_NDEST = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } beat_phase_t;
endpackage

// File: rtl/voq_free_pool.sv
// Module voq_free_pool
// Tracks unused packet slots with a bitmap (1 = free) and offers the lowest
// free slot for allocation. Assumes the caller allocates only when has_free
// is high and frees only slots that are in use; an alloc and a free in the
// same cycle always name different slots.
module voq_free_pool #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    output logic [IW-1:0] alloc_idx,
    output logic          has_free,
    input  logic          free_en,
    input  logic [IW-1:0] free_idx
);
    logic [DEPTH-1:0] free_mask;
    logic [DEPTH-1:0] free_mask_nxt;

    // Pick the lowest-numbered free slot.
    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_mask[i]) alloc_idx = IW'(i);
        end
    end

    assign has_free = |free_mask;

    // Apply this cycle's allocation and release to the bitmap.
    always_comb begin
        free_mask_nxt = free_mask;
        if (alloc_en) free_mask_nxt[alloc_idx] = 1'b0;
        if (free_en)  free_mask_nxt[free_idx]  = 1'b1;
    end

    // Bitmap register; every slot is free after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) free_mask <= '1;
        else        free_mask <= free_mask_nxt;
    end

    AST_NO_ALLOC_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (free_mask != '0)); // R7
    AST_FREE_ONLY_USED: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> !free_mask[free_idx]); // R10
endmodule

// File: rtl/voq_link_table.sv
// Module voq_link_table
// Keeps one linked-list queue per destination: head and tail slot arrays,
// a per-destination occupancy count and a next-slot array for the pool.
// Assumes deq_en is raised only for a non-empty queue and enq_slot is a
// free slot. Handles enqueue and dequeue of one queue in the same cycle.
module voq_link_table #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned NDEST = 8,
    localparam int unsigned IW = $clog2(DEPTH),
    localparam int unsigned DW = $clog2(NDEST),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_en,
    input  logic [DW-1:0]    enq_dest,
    input  logic [IW-1:0]    enq_slot,
    input  logic             deq_en,
    input  logic [DW-1:0]    deq_dest,
    output logic [IW-1:0]    deq_slot,
    output logic [NDEST-1:0] nonempty
);
    logic [IW-1:0] head_q   [NDEST];
    logic [IW-1:0] tail_q   [NDEST];
    logic [CW-1:0] cnt_q    [NDEST];
    logic [IW-1:0] next_q   [DEPTH];
    logic          same_one;

    assign deq_slot = head_q[deq_dest];

    // A dequeue empties a one-packet queue while an enqueue refills it.
    assign same_one = enq_en && deq_en && (enq_dest == deq_dest) &&
                      (cnt_q[enq_dest] == CW'(1));

    // Per-destination non-empty flags.
    generate
        for (genvar g = 0; g < NDEST; g++) begin : g_flag
            assign nonempty[g] = (cnt_q[g] != '0);
        end
    endgenerate

    // Head, tail and next-slot updates; a same-cycle enqueue wins on head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < NDEST; d++) begin
                head_q[d] <= '0;
                tail_q[d] <= '0;
            end
            for (int s = 0; s < DEPTH; s++) next_q[s] <= '0;
        end else begin
            if (deq_en) head_q[deq_dest] <= next_q[head_q[deq_dest]];
            if (enq_en) begin
                if (cnt_q[enq_dest] == '0 || same_one) head_q[enq_dest] <= enq_slot;
                else next_q[tail_q[enq_dest]] <= enq_slot;
                tail_q[enq_dest] <= enq_slot;
            end
        end
    end

    // Occupancy counts per destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < NDEST; d++) cnt_q[d] <= '0;
        end else begin
            for (int d = 0; d < NDEST; d++) begin
                cnt_q[d] <= cnt_q[d]
                    + {{(CW-1){1'b0}}, (enq_en && enq_dest == DW'(d))}
                    - {{(CW-1){1'b0}}, (deq_en && deq_dest == DW'(d))};
            end
        end
    end

    AST_DEQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        deq_en |-> (cnt_q[deq_dest] != '0)); // R6
    AST_ENQ_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        enq_en |-> (cnt_q[enq_dest] < CW'(DEPTH))); // R7
    AST_SINGLE_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        same_one |=> (head_q[$past(enq_dest)] == $past(enq_slot))); // R9
endmodule

// File: rtl/voq_serializer.sv
// Module voq_serializer
// Shift register that sends a loaded packet as two half-width beats, upper
// half first, with a valid flag and a second-beat marker. Assumes load is
// raised only while busy is low; busy is high while the upper beat shows.
module voq_serializer
    import voq_pkg::*;
#(
    parameter int unsigned PKT_W = 72,
    localparam int unsigned BW = PKT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PKT_W-1:0] pkt,
    output logic             busy,
    output logic             out_valid,
    output logic [BW-1:0]    out_beat,
    output logic             out_last
);
    beat_phase_t      phase_q;
    logic [PKT_W-1:0] shreg_q;

    // Load, shift by one half, or go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            shreg_q <= '0;
        end else if (load) begin
            phase_q <= PH_HIGH;
            shreg_q <= pkt;
        end else if (phase_q == PH_HIGH) begin
            phase_q <= PH_LOW;
            shreg_q <= shreg_q << BW;
        end else begin
            phase_q <= PH_IDLE;
        end
    end

    assign out_beat  = shreg_q[PKT_W-1 -: BW];
    assign out_valid = (phase_q != PH_IDLE);
    assign out_last  = (phase_q == PH_LOW);
    assign busy      = (phase_q == PH_HIGH);

    AST_LOW_FOLLOWS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_last)); // R4
    AST_NO_MIDPACKET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(out_valid && !out_last)); // R8
endmodule

// File: rtl/voq_link_buffer.sv
// Module voq_link_buffer
// Input-side packet buffer with one linked-list queue per destination in a
// shared slot pool. Packets are refused while the pool is full. A transmit
// request dequeues the head of the named queue into the two-beat serializer.
// Assumes the sender holds a packet while in_full is high.
module voq_link_buffer
    import voq_pkg::*;
#(
    parameter int unsigned PKT_W = VOQ_PKT_W,
    parameter int unsigned DEPTH = VOQ_DEPTH,
    parameter int unsigned NDEST = VOQ_NDEST,
    localparam int unsigned IW = $clog2(DEPTH),
    localparam int unsigned DW = $clog2(NDEST),
    localparam int unsigned BW = PKT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             in_full,
    output logic [NDEST-1:0] req_vec,
    input  logic             tx_req,
    input  logic [DW-1:0]    tx_dest,
    output logic             tx_empty,
    output logic             out_valid,
    output logic [BW-1:0]    out_beat,
    output logic             out_last
);
    logic [PKT_W-1:0] pkt_mem [DEPTH];
    logic [IW-1:0]    alloc_idx;
    logic [IW-1:0]    head_slot;
    logic             has_free;
    logic             ser_busy;
    logic             enq_go;
    logic             deq_go;
    logic             tx_take;
    logic [DW-1:0]    enq_dest;
    logic [NDEST-1:0] nonempty;

    assign enq_dest = in_pkt[PKT_W-1 -: DW];
    assign enq_go   = in_valid && has_free;
    assign tx_take  = tx_req && !ser_busy;
    assign deq_go   = tx_take && nonempty[tx_dest];
    assign in_full  = !has_free;
    assign req_vec  = nonempty;

    voq_free_pool #(.DEPTH(DEPTH)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (enq_go),
        .alloc_idx (alloc_idx),
        .has_free  (has_free),
        .free_en   (deq_go),
        .free_idx  (head_slot)
    );

    voq_link_table #(.DEPTH(DEPTH), .NDEST(NDEST)) u_links (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq_en   (enq_go),
        .enq_dest (enq_dest),
        .enq_slot (alloc_idx),
        .deq_en   (deq_go),
        .deq_dest (tx_dest),
        .deq_slot (head_slot),
        .nonempty (nonempty)
    );

    voq_serializer #(.PKT_W(PKT_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (deq_go),
        .pkt       (pkt_mem[head_slot]),
        .busy      (ser_busy),
        .out_valid (out_valid),
        .out_beat  (out_beat),
        .out_last  (out_last)
    );

    // Packet storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (enq_go) pkt_mem[alloc_idx] <= in_pkt;
    end

    // One-cycle flag for an accepted request that found its queue empty.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_empty <= 1'b0;
        else        tx_empty <= tx_take && !nonempty[tx_dest];
    end

    AST_EMPTY_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !out_valid); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full && !deq_go) |=> in_full); // R7
    AST_REQ_AFTER_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
        enq_go |=> req_vec[$past(enq_dest)]); // R2
endmodule

// File: tb/voq_link_buffer_tb.sv
module voq_link_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [71:0] in_pkt = '0;
    logic        in_full;
    logic [7:0]  req_vec;
    logic        tx_req = 1'b0;
    logic [2:0]  tx_dest = '0;
    logic        tx_empty;
    logic        out_valid;
    logic [35:0] out_beat;
    logic        out_last;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;
    string cur_tag = "R3";

    logic [71:0] mq [8][$];
    logic [71:0] out_q [$];
    int          total = 0;
    int          ph = 0;
    bit          exp_empty = 1'b0;
    int          tag_ctr = 1;

    always #10 clk = ~clk;

    voq_link_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
        .in_full(in_full), .req_vec(req_vec), .tx_req(tx_req), .tx_dest(tx_dest),
        .tx_empty(tx_empty), .out_valid(out_valid), .out_beat(out_beat),
        .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [71:0] mk(input logic [2:0] d);
        logic [31:0] t = tag_ctr;
        tag_ctr++;
        return {d, 5'd0, t, ~t};
    endfunction

    // Driver: apply one cycle of stimulus, then advance the model.
    task automatic step(input bit ev, input logic [71:0] p, input bit tv, input logic [2:0] d);
        bit was_full;
        bit take;
        @(negedge clk);
        in_valid = ev; in_pkt = p; tx_req = tv; tx_dest = d;
        @(posedge clk);
        was_full = (total == 32);
        take = tv && (ph != 1);
        exp_empty = take && (mq[d].size() == 0);
        if (take && mq[d].size() > 0) begin
            out_q.push_back(mq[d].pop_front());
            total--;
            ph = 1;
        end else begin
            ph = (ph == 1) ? 2 : 0;
        end
        if (ev && !was_full) begin
            mq[p[71:69]].push_back(p);
            total++;
        end
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 3'd0);
    endtask

    task automatic enq(input logic [2:0] d);
        step(1'b1, mk(d), 1'b0, 3'd0);
    endtask

    task automatic tx_one(input logic [2:0] d);
        step(1'b0, '0, 1'b1, d);
        idle();
    endtask

    task automatic drain();
        while (total > 0) begin
            for (int d = 0; d < 8; d++) begin
                if (mq[d].size() > 0) tx_one(3'(d));
            end
        end
        idle(); idle();
    endtask

    // Monitor: compare outputs with the model away from the clock edge.
    always @(negedge clk) begin
        if (mon_en) begin
            logic [7:0] ev;
            for (int d = 0; d < 8; d++) ev[d] = (mq[d].size() > 0);
            chk(req_vec == ev, "R5", "req_vec", 72'(req_vec), 72'(ev));
            chk(in_full == (total == 32), "R7", "in_full", 72'(in_full), 72'(total == 32));
            chk(tx_empty == exp_empty, "R6", "tx_empty", 72'(tx_empty), 72'(exp_empty));
            chk({out_valid, out_last} == {ph != 0, ph == 2}, "R4", "valid/last",
                72'({out_valid, out_last}), 72'({ph != 0, ph == 2}));
            if (out_valid && out_q.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected beat", 72'(out_beat), 72'(0));
            end else if (out_valid && !out_last) begin
                chk(out_beat == out_q[0][71:36], cur_tag, "upper beat",
                    72'(out_beat), 72'(out_q[0][71:36]));
            end else if (out_valid && out_last) begin
                chk(out_beat == out_q[0][35:0], cur_tag, "lower beat",
                    72'(out_beat), 72'(out_q[0][35:0]));
                void'(out_q.pop_front());
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk({in_full, req_vec, out_valid, out_last, tx_empty} == '0, "R1", "reset outputs",
            72'({in_full, req_vec, out_valid, out_last, tx_empty}), 72'(0));
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R2 R3: a few destinations, then ordered drain
        cur_tag = "R2";
        enq(3'd0); enq(3'd3); enq(3'd7); enq(3'd3); enq(3'd3);
        idle();
        cur_tag = "R3";
        tx_one(3'd3); tx_one(3'd0); tx_one(3'd3);

        // R6: request for an empty queue
        cur_tag = "R6";
        tx_one(3'd5); idle();

        // R8: request during upper beat ignored, during lower beat accepted
        cur_tag = "R8";
        enq(3'd7); enq(3'd1);
        step(1'b0, '0, 1'b1, 3'd3);
        step(1'b0, '0, 1'b1, 3'd7);
        step(1'b0, '0, 1'b1, 3'd7);
        step(1'b0, '0, 1'b1, 3'd1);
        idle(); idle();
        drain();

        // R7 R10: fill the pool, overflow attempts, drain, refill
        for (int round = 0; round < 2; round++) begin
            cur_tag = (round == 0) ? "R7" : "R10";
            for (int i = 0; i < 32; i++) enq(3'(i * 5));
            for (int i = 0; i < 3; i++) enq(3'(i));
            idle();
            drain();
        end

        // R9: same-cycle enqueue and dequeue on one queue
        cur_tag = "R9";
        enq(3'd2);
        step(1'b1, mk(3'd2), 1'b1, 3'd2);
        idle();
        step(1'b1, mk(3'd4), 1'b1, 3'd4);
        idle();
        enq(3'd6); enq(3'd6);
        step(1'b1, mk(3'd6), 1'b1, 3'd6);
        idle();
        drain();

        // R3: random mixed traffic
        cur_tag = "R3";
        for (int i = 0; i < 600; i++) begin
            bit ev = ($urandom_range(0, 99) < 55);
            bit tv = ($urandom_range(0, 99) < 45);
            step(ev, mk(3'($urandom_range(0, 7))), tv, 3'($urandom_range(0, 7)));
        end
        drain();
        idle(); idle();
        chk(out_q.size() == 0, "R3", "beats left unsent", 72'(out_q.size()), 72'(0));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule